// File: doc/BRIEF.md
# Extended-Range High-Phase Timer

This block measures how long a slow digital input stays high. A fixed prescaler divides the system clock, and the result drives a free-running up-counter. The block samples that counter when the synchronized input rises and again when it falls. It also counts how many times the counter rolls over while the high phase is open. From the two samples and the rollover count it forms one wide width value. The value is in counter ticks, so high phases many times longer than one counter revolution can be measured. With the default settings this covers inputs slower than 1 Hz on a 60 MHz clock.

The result is held with a valid flag until the consumer acknowledges it. A new rising edge that arrives while a result is still pending is ignored, so the held value cannot be corrupted. If the rollover count would exceed its own width, the measurement is flagged as an overflow error instead.

Top module: `hiphase_meter`

## Requirements
- R1: While `en` is high the tick counter advances by one every PRESCALE clocks. It wraps from 2^CNT_W-1 to 0, and that wrap is the rollover event. While `en` is low the prescaler and the counter hold.
- R2: `sig_in` passes through a two-flop synchronizer. The counter value is sampled at the clock where the synchronized input is first seen high, and again where it is first seen low. After a reset-release the counter value at the k-th clock edge is floor(k/PRESCALE), so the reported width equals the number of ticks between the two samples.
- R3: Rollovers are counted only between the rising sample and the falling sample. Rollovers during the low phase do not enter any result, and the count starts from zero for every measurement.
- R4: When the falling sample is numerically below the rising sample, the modular difference already holds one rollover, and that rollover is not added a second time.
- R5: A rollover on the same tick as the rising sample is counted, because it follows the sampled value. A rollover on the same tick as the falling sample is not counted.
- R6: `valid_out` rises one clock after the falling sample. It then stays high with `width_out` unchanged until `ack` is high on a clock edge, which clears it.
- R7: A rising edge seen while `valid_out` is high, including one that arrives on the same clock as `ack`, is ignored together with its falling edge. No new result appears.
- R8: The rollover count saturates at 2^EXT_W-1. One more rollover ends that measurement with `ovf_err_out` high, `width_out` all ones and `valid_out` high. `ack` clears both flags.
- R9: Dropping `en` abandons an open measurement, and edges seen while `en` is low start none. No result appears from either.
- R10: Synchronous reset clears the samples, the rollover count, `width_out`, `valid_out` and `ovf_err_out`, and the block then waits for a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Runs the time base and the measurement |
| sig_in | input | 1 | Asynchronous signal whose high phase is measured |
| ack | input | 1 | Consumer has taken the result |
| width_out | output | CNT_W+EXT_W | High-phase length in ticks |
| valid_out | output | 1 | Result pending |
| ovf_err_out | output | 1 | Pending result overflowed the rollover count |

## Verification
Two pairs of events can fall on the same clock. A counter rollover can coincide with either edge sample, and a consumer acknowledge can coincide with a new rising edge. The bench keeps its own count of clock edges since reset. It starts a pulse on the edge where the sampled counter value is the top value, then on the edge where the fall lands on the rollover, and checks both widths against the floor-of-ticks formula. It then raises `ack` on exactly the clock where the synchronized rise is detected and checks that no fresh result appears afterwards.

// File: rtl/hiphase_pkg.sv
package hiphase_pkg;

  typedef enum logic {
    MS_WAIT_RISE = 1'b0,
    MS_OPEN      = 1'b1
  } meas_state_e;

endpackage

// File: rtl/hiphase_sync.sv
module hiphase_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise_evt,
  output logic fall_evt
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= sig_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rise_evt = chain_q[STAGES-1] & ~prev_q;
  assign fall_evt = ~chain_q[STAGES-1] & prev_q;

  // R2: an edge event lasts a single clock
  assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> !rise_evt);
  assert_fall_single_R2: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> !fall_evt);

endmodule

// File: rtl/hiphase_timebase.sv
module hiphase_timebase #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             wrap
);

  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0]  div_q;
  logic [CNT_W-1:0] count_q;

  assign tick  = en && (div_q == PS_LAST);
  assign wrap  = tick && (count_q == '1);
  assign count = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (en) begin
      div_q <= tick ? '0 : div_q + PS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (tick) count_q <= count_q + CNT_W'(1);
  end

  // R1: the counter steps by one on a tick and holds otherwise
  assert_step_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> (count_q == CNT_W'($past(count_q) + CNT_W'(1))));
  assert_hold_between_R1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count_q));
  assert_rollover_to_zero_R1: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (count_q == '0));

endmodule

// File: rtl/hiphase_capture.sv
module hiphase_capture
  import hiphase_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int EXT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   ack,
  input  logic                   rise_evt,
  input  logic                   fall_evt,
  input  logic [CNT_W-1:0]       count,
  input  logic                   wrap,
  output logic [CNT_W+EXT_W-1:0] width,
  output logic                   valid,
  output logic                   ovf_err
);

  localparam int RES_W = CNT_W + EXT_W;

  meas_state_e      state_q;
  logic [CNT_W-1:0] rise_cap_q;
  logic [EXT_W-1:0] ext_q;
  logic             ovf_pend_q;
  logic [RES_W-1:0] width_q;
  logic             valid_q;
  logic             err_q;

  // named events for the checks below
  logic accept_rise;
  logic close_meas;
  logic count_wrap;
  logic ext_full;

  assign accept_rise = en && (state_q == MS_WAIT_RISE) && rise_evt && !valid_q;
  assign close_meas  = en && (state_q == MS_OPEN) && fall_evt;
  assign count_wrap  = en && (state_q == MS_OPEN) && !fall_evt && wrap;
  assign ext_full    = (ext_q == '1);

  // Elapsed ticks from two samples and the rollovers counted between them.
  function automatic logic [RES_W-1:0] span_ticks(
    input logic [CNT_W-1:0] fall_v,
    input logic [CNT_W-1:0] rise_v,
    input logic [EXT_W-1:0] rolls
  );
    logic [CNT_W-1:0] diff;
    logic [EXT_W-1:0] whole;
    diff  = fall_v - rise_v;
    whole = (fall_v < rise_v) ? rolls - EXT_W'(1) : rolls;
    return {whole, diff};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= MS_WAIT_RISE;
      rise_cap_q <= '0;
      ext_q      <= '0;
      ovf_pend_q <= 1'b0;
      width_q    <= '0;
      valid_q    <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (ack) begin
        valid_q <= 1'b0;
        err_q   <= 1'b0;
      end
      if (!en) begin
        state_q    <= MS_WAIT_RISE;
        ext_q      <= '0;
        ovf_pend_q <= 1'b0;
      end else if (accept_rise) begin
        rise_cap_q <= count;
        ext_q      <= wrap ? EXT_W'(1) : '0;
        ovf_pend_q <= 1'b0;
        state_q    <= MS_OPEN;
      end else if (close_meas) begin
        width_q    <= ovf_pend_q ? '1 : span_ticks(count, rise_cap_q, ext_q);
        err_q      <= ovf_pend_q;
        valid_q    <= 1'b1;
        ext_q      <= '0;
        ovf_pend_q <= 1'b0;
        state_q    <= MS_WAIT_RISE;
      end else if (count_wrap) begin
        if (ext_full) ovf_pend_q <= 1'b1;
        else          ext_q      <= ext_q + EXT_W'(1);
      end
    end
  end

  assign width   = width_q;
  assign valid   = valid_q;
  assign ovf_err = err_q;

  // R3: no rollovers are held outside an open measurement
  assert_idle_count_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == MS_WAIT_RISE) |-> (ext_q == '0));
  // R4: a borrowed difference always has a counted rollover to absorb it
  assert_borrow_backed_R4: assert property (@(posedge clk) disable iff (rst)
    (close_meas && (count < rise_cap_q)) |-> (ext_q != '0 || ovf_pend_q));
  // R6: a pending result is held until acknowledged
  assert_result_held_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ack) |=> (valid_q && $stable(width_q)));
  // R7: a rise during a pending result leaves the rising sample alone
  assert_rise_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && rise_evt) |=> ($stable(rise_cap_q) && state_q == MS_WAIT_RISE));
  // R8: the error flag only accompanies a pending result
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    err_q |-> valid_q);

endmodule

// File: rtl/hiphase_meter.sv
module hiphase_meter #(
  parameter int CNT_W       = 16,
  parameter int EXT_W       = 16,
  parameter int PRESCALE    = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   sig_in,
  input  logic                   ack,
  output logic [CNT_W+EXT_W-1:0] width_out,
  output logic                   valid_out,
  output logic                   ovf_err_out
);

  logic             rise_evt;
  logic             fall_evt;
  logic [CNT_W-1:0] tb_count;
  logic             tb_tick;
  logic             tb_wrap;

  hiphase_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sig_in   (sig_in),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  hiphase_timebase #(
    .CNT_W    (CNT_W),
    .PRESCALE (PRESCALE)
  ) u_timebase (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .count (tb_count),
    .tick  (tb_tick),
    .wrap  (tb_wrap)
  );

  hiphase_capture #(
    .CNT_W (CNT_W),
    .EXT_W (EXT_W)
  ) u_capture (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .ack      (ack),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .count    (tb_count),
    .wrap     (tb_wrap),
    .width    (width_out),
    .valid    (valid_out),
    .ovf_err  (ovf_err_out)
  );

  // R1: a rollover only happens on a prescaler tick
  assert_wrap_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
    tb_wrap |-> tb_tick);

endmodule

// File: tb/hiphase_meter_test.sv
module hiphase_meter_test;

  localparam int CNT_W = 8;
  localparam int EXT_W = 4;
  localparam int PS    = 4;
  localparam int RES_W = CNT_W + EXT_W;
  localparam int REV   = PS * (1 << CNT_W);   // clocks per counter revolution

  // phase = (capture edge index) mod REV, high length in clocks, expected ticks
  localparam int NVEC = 10;
  localparam int VEC [NVEC][3] = '{
    '{0,    3,     0},
    '{0,    40,    10},
    '{1,    40,    10},
    '{3,    1,     1},
    '{1000, 100,   25},
    '{0,    1024,  256},
    '{512,  3000,  750},
    '{1023, 8,     2},
    '{1015, 8,     2},
    '{100,  15000, 3750}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en = 1'b1;
  logic             sig_in = 1'b0;
  logic             ack = 1'b0;
  logic [RES_W-1:0] width_out;
  logic             valid_out;
  logic             ovf_err_out;

  int n_checks = 0;
  int n_fail   = 0;
  int edge_n   = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edge_n <= 0;
    else     edge_n <= edge_n + 1;
  end

  hiphase_meter #(
    .CNT_W    (CNT_W),
    .EXT_W    (EXT_W),
    .PRESCALE (PS)
  ) uut (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .sig_in      (sig_in),
    .ack         (ack),
    .width_out   (width_out),
    .valid_out   (valid_out),
    .ovf_err_out (ovf_err_out)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // capture edge = drive edge + 2
  task automatic align(input int phase);
    while (((edge_n + 2) % REV) != phase) @(negedge clk);
  endtask

  task automatic pulse(input int high_len);
    sig_in = 1'b1;
    repeat (high_len) @(negedge clk);
    sig_in = 1'b0;
  endtask

  task automatic wait_valid(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (valid_out) break;
      @(negedge clk);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 width after reset", int'(width_out), 0);
    check("R10 valid after reset", int'(valid_out), 0);
    check("R10 err after reset", int'(ovf_err_out), 0);

    // R1 R2 R3 R4 R5: vector table
    for (int v = 0; v < NVEC; v++) begin
      align(VEC[v][0]);
      pulse(VEC[v][1]);
      @(negedge clk);
      wait_valid(16);
      check($sformatf("R2 R3 R4 R5 vec%0d valid", v), int'(valid_out), 1);
      check($sformatf("R1 R2 R3 R4 R5 vec%0d width", v), int'(width_out), VEC[v][2]);
      check($sformatf("R8 vec%0d err", v), int'(ovf_err_out), 0);
      do_ack();
      check($sformatf("R6 vec%0d cleared by ack", v), int'(valid_out), 0);
      repeat (5) @(negedge clk);
    end

    // R6 hold, R7 rise while pending
    align(0);
    pulse(80);
    @(negedge clk);
    wait_valid(16);
    check("R6 valid", int'(valid_out), 1);
    check("R6 width", int'(width_out), 20);
    pulse(40);
    repeat (10) @(negedge clk);
    check("R6 held without ack", int'(valid_out), 1);
    check("R7 width unchanged by pulse while pending", int'(width_out), 20);
    do_ack();
    repeat (10) @(negedge clk);
    check("R7 no result from ignored pulse", int'(valid_out), 0);

    // R7: ack on the same clock as the detected rise
    align(0);
    pulse(4);
    @(negedge clk);
    wait_valid(16);
    check("R7 setup result", int'(width_out), 1);
    sig_in = 1'b1;          // rise detected at the edge two clocks ahead
    @(negedge clk);
    @(negedge clk);
    ack = 1'b1;             // high across that same edge
    @(negedge clk);
    ack = 1'b0;
    repeat (20) @(negedge clk);
    sig_in = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 rise coincident with ack ignored", int'(valid_out), 0);

    // R8: rollover count overflow
    align(0);
    pulse(16400);
    @(negedge clk);
    wait_valid(16);
    check("R8 valid on overflow", int'(valid_out), 1);
    check("R8 err flag", int'(ovf_err_out), 1);
    check("R8 width saturated", int'(width_out), (1 << RES_W) - 1);
    do_ack();
    check("R8 err cleared by ack", int'(ovf_err_out), 0);

    // R9: enable low abandons an open measurement and ignores edges
    sig_in = 1'b1;
    repeat (10) @(negedge clk);
    en = 1'b0;
    repeat (5) @(negedge clk);
    en = 1'b1;
    repeat (10) @(negedge clk);
    sig_in = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 abandoned measurement gives no result", int'(valid_out), 0);
    en = 1'b0;
    pulse(30);
    repeat (10) @(negedge clk);
    en = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 edges while disabled ignored", int'(valid_out), 0);

    // R10: reset during an open measurement, then a fresh one
    sig_in = 1'b1;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    sig_in = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 no result after reset mid-measurement", int'(valid_out), 0);
    check("R10 width cleared", int'(width_out), 0);
    align(2);
    pulse(100);
    @(negedge clk);
    wait_valid(16);
    check("R10 R2 measurement after reset", int'(width_out), 25);
    do_ack();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule